// File: doc/BRIEF.md
# Interrupt-Driven Sampling Converter Reader

This block sits on the host side of a 12-bit sampling analog-to-digital converter that runs in its interrupt handshake mode. It runs a free-running sample schedule. For each slot it selects the chip, sets up the two-way input multiplexer select, and sends a low pulse on the sample/hold line of a fixed length. It then waits for the converter to pull its interrupt line low. When that happens it drives the read strobe for long enough to cover the converter's access time, captures the 12-bit word, and releases the bus.

Each result leaves on a valid/ready stream together with the channel it was taken from. The channel either alternates on every conversion or follows a fixed select input. A power-down request puts the converter in standby between transactions. After the request is released, the block waits out a wake-up interval before the next sample. A missing interrupt ends the transaction with a one-cycle error pulse. A result that arrives while the stream is still stalled is dropped, and a one-cycle overrun pulse marks the drop.

All timing windows are clock-cycle parameters. Elaboration rejects any value that breaks the converter's limits: the two legal pulse-width bands, the minimum sample period, the select hold, the access time and the wake-up time.

Top module: `adc_irq_reader`

## Requirements
- R1: While conversions complete normally, successive falling edges of `adc_sh_n` are exactly `PERIOD_CYC` cycles apart. `adc_cs_n` is low whenever `adc_sh_n` is low, and it is low for at least `CS_LEAD_CYC` cycles before every falling edge.
- R2: Every `adc_sh_n` low pulse lasts exactly `SH_LOW_CYC` cycles.
- R3: `adc_sel` does not change during the `CS_LEAD_CYC` cycles before a falling edge of `adc_sh_n`. It also does not change during the edge cycle or the `SEL_HOLD_CYC` cycles after it.
- R4: With `chan_alt` = 1, the channel on successive falling edges alternates 0, 1, 0, … starting at 0 after reset. With `chan_alt` = 0, the channel equals `chan_fixed`. Channel 0 is `adc_sel` = 0 and channel 1 is `adc_sel` = 1.
- R5: `adc_rd_n` falls in the cycle after a cycle in which `adc_int_n` was sampled low during a conversion. It stays low for `ACC_CYC`+1 cycles, and the word on `adc_data` at the clock edge that releases it is the result.
- R6: A captured result appears on `m_data`, with `m_chan` equal to the channel of its conversion, in the cycle in which `adc_rd_n` returns high. `m_valid`, `m_data` and `m_chan` hold until a cycle with `m_ready` high.
- R7: If `m_valid` is high and `m_ready` is low at the clock edge that captures a new result, that result is discarded, the held beat is unchanged, and `overrun` is high for that one cycle.
- R8: If `adc_int_n` is not seen low within 2×`CONV_NOM_CYC` cycles after the sample pulse ends, `timeout_err` is high for one cycle. That cycle comes `SH_LOW_CYC`+2×`CONV_NOM_CYC` cycles after the falling edge. No read is issued, and sampling then resumes.
- R9: A high `pd_req` drives `adc_pd_n` low once the current transaction ends, and only then. While `adc_pd_n` is low, `adc_cs_n`, `adc_sh_n` and `adc_rd_n` stay high. After `pd_req` drops, the first falling edge of `adc_sh_n` comes at least `WAKE_CYC` cycles after `adc_pd_n` rises.
- R10: During reset `adc_pd_n` is low, `adc_cs_n`, `adc_sh_n` and `adc_rd_n` are high, and `m_valid`, `overrun` and `timeout_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Standby request |
| chan_alt | input | 1 | 1 = alternate channels, 0 = use `chan_fixed` |
| chan_fixed | input | 1 | Channel used when not alternating |
| adc_int_n | input | 1 | Conversion-complete interrupt from the converter, active low |
| adc_data | input | 12 | Converter data bus |
| adc_pd_n | output | 1 | Converter power-down, active low |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sh_n | output | 1 | Sample/hold strobe; the falling edge starts a conversion |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_sel | output | 1 | Multiplexer channel select |
| m_valid | output | 1 | Result stream valid |
| m_ready | input | 1 | Result stream ready |
| m_data | output | 12 | Result word |
| m_chan | output | 1 | Channel the result was taken from |
| overrun | output | 1 | One-cycle pulse: a result was dropped |
| timeout_err | output | 1 | One-cycle pulse: the interrupt never came |

## Verification
A fault in the period counter shows up at the second sample edge as a wrong spacing between falling edges. A fault in the select register shows up at the very next sample edge, either as a wrong channel or as a select change inside the guarded window. A sequencer stuck in the wrong state shows up on the pins within one transaction. Typical signs are a read with no interrupt before it, a strobe of the wrong length, or strobe activity during standby. A fault in the output register shows up at the port in the cycle after a capture or a handshake, because the bench models the stream register cycle by cycle and compares valid, data, channel and overrun on every clock.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int DATA_W = 12;

    typedef enum logic [2:0] {
        ST_DOWN,
        ST_WAKE,
        ST_IDLE,
        ST_ARM,
        ST_SAMPLE,
        ST_CONV,
        ST_ACCESS,
        ST_CAPT
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic sh_n;
        logic rd_n;
        logic pd_n;
    } adc_pins_t;

    typedef struct packed {
        logic              chan;
        logic [DATA_W-1:0] data;
    } sample_t;

    // Pulse width must sit in the short band or the long band.
    function automatic bit sh_width_legal(int ns);
        return ((ns >= 5) && (ns <= 40)) || ((ns >= 150) && (ns <= 550));
    endfunction

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic adc_pins_t pins_for(seq_state_e s);
        adc_pins_t p;
        p = '{cs_n: 1'b1, sh_n: 1'b1, rd_n: 1'b1, pd_n: 1'b1};
        case (s)
            ST_DOWN:    p.pd_n = 1'b0;
            ST_ARM,
            ST_CONV:    p.cs_n = 1'b0;
            ST_SAMPLE:  begin p.cs_n = 1'b0; p.sh_n = 1'b0; end
            ST_ACCESS,
            ST_CAPT:    begin p.cs_n = 1'b0; p.rd_n = 1'b0; end
            default:    ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int PERIOD_CYC   = 100,
    parameter int SH_LOW_CYC   = 3,
    parameter int CS_LEAD_CYC  = 2,
    parameter int SEL_HOLD_CYC = 19,
    parameter int ACC_CYC      = 13,
    parameter int TO_CYC       = 196,
    parameter int WAKE_CYC     = 100
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pd_req,
    input  logic      int_n,
    output adc_pins_t pins,
    output logic      sel_upd,
    output logic      sample_start,
    output logic      capture,
    output logic      timeout_pulse
);

    localparam int CNT_MAX = max_of4(PERIOD_CYC, TO_CYC, WAKE_CYC, ACC_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PER_FULL  = CW'(PERIOD_CYC);
    localparam logic [CW-1:0] ARM_AT    = CW'(PERIOD_CYC - CS_LEAD_CYC - 1);
    localparam logic [CW-1:0] HOLD_DONE = CW'(SEL_HOLD_CYC);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] step_q;   // cycles spent in the current state
    logic [CW-1:0] per_q;    // cycles since the last sample edge, saturating
    logic          to_d;

    always_comb begin
        state_d = state_q;
        to_d    = 1'b0;
        unique case (state_q)
            ST_DOWN:   if (!pd_req) state_d = ST_WAKE;
            ST_WAKE: begin
                if (pd_req)                               state_d = ST_DOWN;
                else if (step_q == CW'(WAKE_CYC - 1))     state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (pd_req)                               state_d = ST_DOWN;
                else if (per_q >= ARM_AT)                 state_d = ST_ARM;
            end
            ST_ARM:    if (step_q == CW'(CS_LEAD_CYC - 1)) state_d = ST_SAMPLE;
            ST_SAMPLE: if (step_q == CW'(SH_LOW_CYC - 1))  state_d = ST_CONV;
            ST_CONV: begin
                if (!int_n)                               state_d = ST_ACCESS;
                else if (step_q == CW'(TO_CYC - 1)) begin
                    state_d = ST_IDLE;
                    to_d    = 1'b1;
                end
            end
            ST_ACCESS: if (step_q == CW'(ACC_CYC - 1))     state_d = ST_CAPT;
            ST_CAPT:                                      state_d = ST_IDLE;
            default:                                      state_d = ST_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_DOWN;
            step_q        <= '0;
            per_q         <= PER_FULL;
            pins          <= pins_for(ST_DOWN);
            timeout_pulse <= 1'b0;
        end else begin
            state_q       <= state_d;
            pins          <= pins_for(state_d);
            timeout_pulse <= to_d;
            if (state_d != state_q)  step_q <= '0;
            else if (step_q != '1)   step_q <= step_q + 1'b1;
            if ((state_d == ST_SAMPLE) && (state_q != ST_SAMPLE)) per_q <= '0;
            else if (state_q == ST_WAKE)                           per_q <= PER_FULL;
            else if (per_q < PER_FULL)                             per_q <= per_q + 1'b1;
        end
    end

    assign sel_upd      = (state_q == ST_WAKE) || ((state_q == ST_IDLE) && (per_q >= HOLD_DONE));
    assign sample_start = (state_q == ST_ARM) && (state_d == ST_SAMPLE);
    assign capture      = (state_q == ST_CAPT);

endmodule

// File: rtl/adc_rd_chan.sv
module adc_rd_chan (
    input  logic clk,
    input  logic rst,
    input  logic sel_upd,
    input  logic sample_start,
    input  logic mode_alt,
    input  logic fixed_chan,
    output logic sel,
    output logic tag
);

    logic target;

    // tag holds the channel of the latest conversion; alternation flips it
    assign target = mode_alt ? ~tag : fixed_chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
            tag <= 1'b1;
        end else begin
            if (sample_start) tag <= sel;
            if (sel_upd)      sel <= target;
        end
    end

endmodule

// File: rtl/adc_rd_out.sv
module adc_rd_out
    import adc_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              cap_chan,
    input  logic              m_ready,
    output logic              m_valid,
    output sample_t           m_beat,
    output logic              overrun
);

    logic accept;

    assign accept = !m_valid || m_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_beat  <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= capture && !accept;
            if (capture && accept) begin
                m_valid     <= 1'b1;
                m_beat.chan <= cap_chan;
                m_beat.data <= cap_data;
            end else if (m_ready) begin
                m_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_irq_reader.sv
module adc_irq_reader
    import adc_rd_pkg::*;
#(
    parameter int CLK_NS        = 10,
    parameter int PERIOD_CYC    = 100,
    parameter int MIN_PERIOD_NS = 1000,
    parameter int SH_LOW_CYC    = 3,
    parameter int CS_LEAD_CYC   = 2,
    parameter int SEL_HOLD_CYC  = 19,
    parameter int ACC_CYC       = 13,
    parameter int CONV_NOM_CYC  = 98,
    parameter int WAKE_CYC      = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_req,
    input  logic              chan_alt,
    input  logic              chan_fixed,
    input  logic              adc_int_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_pd_n,
    output logic              adc_cs_n,
    output logic              adc_sh_n,
    output logic              adc_rd_n,
    output logic              adc_sel,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_chan,
    output logic              overrun,
    output logic              timeout_err
);

    localparam int TO_CYC = 2 * CONV_NOM_CYC;

    // Elaboration-time limits
    if (!sh_width_legal(SH_LOW_CYC * CLK_NS)) begin : g_bad_sh_width
        $error("sample pulse width outside both legal bands");
    end
    if (PERIOD_CYC * CLK_NS < MIN_PERIOD_NS) begin : g_bad_period
        $error("sample period shorter than converter minimum");
    end
    if (SEL_HOLD_CYC * CLK_NS < 185) begin : g_bad_sel_hold
        $error("select hold window too short");
    end
    if ((ACC_CYC + 1) * CLK_NS < 125) begin : g_bad_access
        $error("read strobe shorter than access time");
    end
    if (WAKE_CYC * CLK_NS < 1000) begin : g_bad_wake
        $error("wake-up wait too short");
    end
    if ((CS_LEAD_CYC < 1) || (PERIOD_CYC <= SEL_HOLD_CYC + CS_LEAD_CYC + 1)) begin : g_bad_slots
        $error("period too short for select hold and chip-select lead");
    end

    adc_pins_t pins;
    sample_t   beat;
    logic      sel_upd, sample_start, capture, chan_tag;

    adc_rd_seq #(
        .PERIOD_CYC  (PERIOD_CYC),
        .SH_LOW_CYC  (SH_LOW_CYC),
        .CS_LEAD_CYC (CS_LEAD_CYC),
        .SEL_HOLD_CYC(SEL_HOLD_CYC),
        .ACC_CYC     (ACC_CYC),
        .TO_CYC      (TO_CYC),
        .WAKE_CYC    (WAKE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .pd_req       (pd_req),
        .int_n        (adc_int_n),
        .pins         (pins),
        .sel_upd      (sel_upd),
        .sample_start (sample_start),
        .capture      (capture),
        .timeout_pulse(timeout_err)
    );

    adc_rd_chan u_chan (
        .clk         (clk),
        .rst         (rst),
        .sel_upd     (sel_upd),
        .sample_start(sample_start),
        .mode_alt    (chan_alt),
        .fixed_chan  (chan_fixed),
        .sel         (adc_sel),
        .tag         (chan_tag)
    );

    adc_rd_out u_out (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .cap_data(adc_data),
        .cap_chan(chan_tag),
        .m_ready (m_ready),
        .m_valid (m_valid),
        .m_beat  (beat),
        .overrun (overrun)
    );

    assign adc_pd_n = pins.pd_n;
    assign adc_cs_n = pins.cs_n;
    assign adc_sh_n = pins.sh_n;
    assign adc_rd_n = pins.rd_n;
    assign m_data   = beat.data;
    assign m_chan   = beat.chan;

endmodule

// File: rtl/adc_irq_reader_chk.sv
module adc_irq_reader_chk
    import adc_rd_pkg::*;
#(
    parameter int SH_LOW_CYC   = 3,
    parameter int SEL_HOLD_CYC = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_pd_n,
    input logic              adc_cs_n,
    input logic              adc_sh_n,
    input logic              adc_rd_n,
    input logic              adc_sel,
    input logic              adc_int_n,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_chan,
    input logic              overrun
);

    int   sh_run;
    int   hold_cnt;
    logic sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_run   <= 0;
            hold_cnt <= SEL_HOLD_CYC;
            sh_q     <= 1'b1;
        end else begin
            sh_q   <= adc_sh_n;
            sh_run <= adc_sh_n ? 0 : sh_run + 1;
            if (sh_q && !adc_sh_n)          hold_cnt <= 0;
            else if (hold_cnt < SEL_HOLD_CYC) hold_cnt <= hold_cnt + 1;
        end
    end

    p_sh_needs_cs_r1: assert property (@(posedge clk) disable iff (rst)
        !adc_sh_n |-> !adc_cs_n);

    p_sh_width_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sh_n) |-> (sh_run == SH_LOW_CYC));

    p_sel_at_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sh_n) |-> $stable(adc_sel));

    p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (hold_cnt < SEL_HOLD_CYC) |-> $stable(adc_sel));

    p_rd_after_int_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_rd_n) |-> $past(!adc_int_n));

    p_stream_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)));

    p_overrun_cause_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(m_valid && !m_ready));

    p_standby_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !adc_pd_n |-> (adc_cs_n && adc_sh_n && adc_rd_n));

endmodule

bind adc_irq_reader adc_irq_reader_chk #(
    .SH_LOW_CYC  (SH_LOW_CYC),
    .SEL_HOLD_CYC(SEL_HOLD_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .adc_pd_n (adc_pd_n),
    .adc_cs_n (adc_cs_n),
    .adc_sh_n (adc_sh_n),
    .adc_rd_n (adc_rd_n),
    .adc_sel  (adc_sel),
    .adc_int_n(adc_int_n),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .m_chan   (m_chan),
    .overrun  (overrun)
);

// File: tb/adc_irq_reader_tb.sv
module adc_irq_reader_tb;

    localparam int PER   = 100;
    localparam int SH    = 3;
    localparam int LEAD  = 2;
    localparam int HOLD  = 19;
    localparam int ACC   = 13;
    localparam int NOM   = 98;
    localparam int WAKE  = 100;
    localparam int TO    = 2 * NOM;
    localparam int CONVT = 60;

    logic        clk = 1'b0, rst = 1'b1;
    logic        pd_req = 1'b0, chan_alt = 1'b1, chan_fixed = 1'b0;
    logic        int_n = 1'b1, m_ready = 1'b1;
    logic [11:0] adc_data = 12'h000;
    logic        adc_pd_n, adc_cs_n, adc_sh_n, adc_rd_n, adc_sel;
    logic        m_valid, m_chan, overrun, timeout_err;
    logic [11:0] m_data;

    always #5 clk = ~clk;

    adc_irq_reader #(
        .CLK_NS(10), .PERIOD_CYC(PER), .MIN_PERIOD_NS(1000), .SH_LOW_CYC(SH),
        .CS_LEAD_CYC(LEAD), .SEL_HOLD_CYC(HOLD), .ACC_CYC(ACC),
        .CONV_NOM_CYC(NOM), .WAKE_CYC(WAKE)
    ) u_dut (
        .clk(clk), .rst(rst), .pd_req(pd_req), .chan_alt(chan_alt),
        .chan_fixed(chan_fixed), .adc_int_n(int_n), .adc_data(adc_data),
        .adc_pd_n(adc_pd_n), .adc_cs_n(adc_cs_n), .adc_sh_n(adc_sh_n),
        .adc_rd_n(adc_rd_n), .adc_sel(adc_sel), .m_valid(m_valid),
        .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
        .overrun(overrun), .timeout_err(timeout_err)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // values of bench-driven inputs as seen at the last rising edge
    logic rdy_e = 1'b1, alt_e = 1'b1, fix_e = 1'b0, int_e = 1'b1;
    always @(posedge clk) begin
        rdy_e <= m_ready;
        alt_e <= chan_alt;
        fix_e <= chan_fixed;
        int_e <= int_n;
    end

    // bench state
    bit   mute = 0;
    int   fall_count = 0;
    logic sh_p = 1'b1, rd_p = 1'b1, pdn_p = 1'b0, sel_p = 1'b0;
    int   last_fall = -1, fall_cyc = -1000, last_sel_chg = -1000, rd_fall_cyc = 0;
    int   cs_run = 0, wake_rise = -1, exp_to_cyc = -1;
    bit   prev_to = 0;
    logic exp_prev_chan = 1'b1;
    // converter model
    int   conv_t = 0, idx = 0, rd_run = 0;
    bit   conv_mute = 0;
    logic conv_ch = 1'b0;
    logic [11:0] pend_d = 12'h000;
    logic pend_c = 1'b0;
    // reference of the output register
    bit   ref_v = 0;
    logic [11:0] ref_d = 12'h000;
    logic ref_c = 1'b0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit   ovr_exp;
            logic exp_ch;
            cyc++;
            if (cyc > 60000) begin
                chk(0, "WATCHDOG", "run did not end", cyc, 60000);
                finish_run();
            end

            // R9: standby keeps the bus quiet
            if (!adc_pd_n)
                chk(adc_cs_n && adc_sh_n && adc_rd_n, "R9", "strobe active in standby",
                    {adc_cs_n, adc_sh_n, adc_rd_n}, 7);
            if (adc_pd_n && !pdn_p) wake_rise = cyc;
            if (!adc_pd_n) last_fall = -1;

            // R3: select changes only outside the guarded window
            if (adc_sel !== sel_p) begin
                chk(cyc - fall_cyc > HOLD, "R3", "select moved after sample edge",
                    cyc - fall_cyc, HOLD + 1);
                last_sel_chg = cyc;
            end

            // sample edge
            if (sh_p && !adc_sh_n) begin
                chk(cs_run >= LEAD, "R1", "chip-select lead cycles", cs_run, LEAD);
                chk(cyc - last_sel_chg >= LEAD, "R3", "select setup cycles",
                    cyc - last_sel_chg, LEAD);
                exp_ch = alt_e ? ~exp_prev_chan : fix_e;
                chk(adc_sel === exp_ch, "R4", "channel at sample edge", adc_sel, exp_ch);
                exp_prev_chan = exp_ch;
                if (last_fall >= 0) begin
                    if (prev_to) chk(cyc - last_fall >= PER, "R1", "spacing after timeout",
                                     cyc - last_fall, PER);
                    else         chk(cyc - last_fall == PER, "R1", "sample spacing",
                                     cyc - last_fall, PER);
                end
                if (wake_rise >= 0) begin
                    chk(cyc - wake_rise >= WAKE, "R9", "wake-up wait", cyc - wake_rise, WAKE);
                    wake_rise = -1;
                end
                last_fall = cyc;
                fall_cyc  = cyc;
                prev_to   = mute;
                if (mute) exp_to_cyc = cyc + SH + TO;
                fall_count++;
                // model: start a conversion
                conv_t    = CONVT;
                conv_ch   = adc_sel;
                conv_mute = mute;
                idx++;
            end else if (conv_t > 0) begin
                conv_t--;
                if (conv_t == 0 && !conv_mute) begin
                    int_n  = 1'b0;
                    pend_d = 12'((idx * 613) + (conv_ch ? 2048 : 0));
                    pend_c = conv_ch;
                end
            end

            // R2: pulse width
            if (!sh_p && adc_sh_n)
                chk(cyc - fall_cyc == SH, "R2", "sample pulse width", cyc - fall_cyc, SH);

            // R5: read handshake
            if (rd_p && !adc_rd_n) begin
                chk(int_e == 1'b0, "R5", "read without interrupt", int_e, 0);
                rd_fall_cyc = cyc;
            end
            if (!rd_p && adc_rd_n)
                chk(cyc - rd_fall_cyc == ACC + 1, "R5", "read strobe width",
                    cyc - rd_fall_cyc, ACC + 1);

            // R8: timeout pulse lands exactly where predicted
            chk(timeout_err === (cyc == exp_to_cyc), "R8", "timeout pulse",
                timeout_err, cyc == exp_to_cyc);

            // R6/R7: reference of the stream register
            ovr_exp = 0;
            if (ref_v && rdy_e) ref_v = 0;
            if (!rd_p && adc_rd_n) begin
                if (ref_v) ovr_exp = 1;
                else begin
                    ref_v = 1; ref_d = pend_d; ref_c = pend_c;
                end
            end
            chk(m_valid === ref_v, "R6", "stream valid", m_valid, ref_v);
            if (ref_v) begin
                chk(m_data === ref_d, "R6", "stream data", m_data, ref_d);
                chk(m_chan === ref_c, "R6", "stream channel", m_chan, ref_c);
            end
            chk(overrun === ovr_exp, "R7", "overrun pulse", overrun, ovr_exp);

            // model: read bus
            if (!adc_rd_n && !adc_cs_n) begin
                int_n = 1'b1;
                rd_run++;
                adc_data = (rd_run >= 5) ? pend_d : 12'h000;
            end else begin
                rd_run   = 0;
                adc_data = 12'h000;
            end

            cs_run = adc_cs_n ? 0 : cs_run + 1;
            sh_p  = adc_sh_n;
            rd_p  = adc_rd_n;
            pdn_p = adc_pd_n;
            sel_p = adc_sel;
        end
    end

    task automatic wait_falls(int n);
        int target;
        target = fall_count + n;
        while (fall_count < target) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(adc_pd_n == 1'b0, "R10", "pd_n in reset", adc_pd_n, 0);
        chk({adc_cs_n, adc_sh_n, adc_rd_n} == 3'b111, "R10", "strobes in reset",
            {adc_cs_n, adc_sh_n, adc_rd_n}, 7);
        chk({m_valid, overrun, timeout_err} == 3'b000, "R10", "flags in reset",
            {m_valid, overrun, timeout_err}, 0);
        rst = 1'b0;

        wait_falls(4);                        // R4 alternating
        chan_alt = 1'b0; chan_fixed = 1'b1;
        wait_falls(3);                        // R4 fixed channel 1
        chan_fixed = 1'b0;
        wait_falls(2);                        // R4 fixed channel 0
        chan_alt = 1'b1;
        wait_falls(2);

        m_ready = 1'b0;                       // R7 stalled stream
        wait_falls(3);
        m_ready = 1'b1;
        wait_falls(2);

        for (int k = 0; k < 400; k++) begin   // R6 irregular ready
            @(negedge clk);
            m_ready = (k % 3) != 0;
        end
        m_ready = 1'b1;
        wait_falls(1);

        mute = 1;                             // R8 missing interrupt
        wait_falls(1);
        mute = 0;
        wait_falls(3);

        pd_req = 1'b1;                        // R9 standby
        begin
            int w;
            w = 0;
            while (adc_pd_n && w < 300) begin @(negedge clk); w++; end
            chk(adc_pd_n == 1'b0, "R9", "standby entered", adc_pd_n, 0);
        end
        repeat (200) @(negedge clk);
        pd_req = 1'b0;
        wait_falls(3);
        repeat (100) @(negedge clk);
        finish_run();
    end

endmodule